// File: doc/BRIEF.md
# Capture/Compare Timer with Pulse Accumulator

This block is a general-purpose timer peripheral on a byte-wide register bus. A 16-bit up-counter advances on the bus clock divided by a power-of-two prescaler. Eight channels sit beside it. Each channel can latch the counter value when its input pin shows a selected edge, or it can act on its output pin when the counter reaches its stored value. The counter rolls over at 0xFFFF. In modulo mode it instead clears after reaching the channel 7 value, which sets the period for simple pulse-width outputs.

A separate 16-bit pulse accumulator has two modes. It counts active edges on its own input pin, or it counts ticks of a fixed divided clock while that pin sits at its active level. Channel events, counter rollover and accumulator rollover each set a sticky flag. Software clears a flag by writing 1 to it.

Sixteen-bit quantities cross the 8-bit bus in two steps. A write to the high byte is held in a staging register and takes effect when the low byte is written. A read of the counter or accumulator high byte latches its low byte, so the following low-byte read belongs to the same value.

Top module: `tmr_pacc`

## Requirements
- R1: After reset, the counter, the accumulator, all channel values, all configuration registers, all flags and all output pins are zero.
- R2: While the enable bit (bit 7 of CTRL, address 0x12) is 1, the counter advances once every 2^s bus cycles, where s is CTRL bits 2:0. While the enable bit is 0, the counter holds its value.
- R3: When the counter advances from 0xFFFF to 0x0000 by rollover, the overflow flag (bit 0 of FLAGM, address 0x19) is set.
- R4: With modulo mode on (CTRL bit 6), an advance from the value held in channel 7 goes to 0x0000 and does not set the overflow flag.
- R5: A channel in capture mode (its MODE bit at address 0x13 is 0) latches the counter and sets its flag (FLAGC bit n, address 0x18) on the edges its 2-bit edge code selects: 00 none, 01 rising, 10 falling, 11 both. Codes for channels 0-3 are in EDGEL (0x14) and for channels 4-7 in EDGEH (0x15), channel n at bits 2(n mod 4)+1 down to 2(n mod 4).
- R6: A channel in compare mode (MODE bit 1) sets its flag when the counter advances from the channel's value. On that advance it applies its 2-bit action to its pin: 00 none, 01 toggle, 10 clear, 11 set. Actions are held in ACTL (0x16) and ACTH (0x17) with the same layout as the edge codes. Pins change only on counter advances.
- R7: A compare channel whose bit is set in PWMEN (0x1A) drives its pin high on every counter wrap (rollover or modulo clear) unless its own compare action fires on the same advance.
- R8: With accumulator control PACTL (0x1C) bit 0 = 1 and bit 1 = 0, the accumulator counts rising edges of pa_in, or falling edges when bit 2 = 1. With bit 0 = 0 it does not count.
- R9: With PACTL bits 1:0 = 11, the accumulator counts one per 2^GATE_LOG2 bus cycles while pa_in is at its active level (high, or low when bit 2 = 1). The divider restarts when the accumulator is disabled.
- R10: A rollover of the accumulator from 0xFFFF sets bit 1 of FLAGM.
- R11: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R12: Reading the high byte of the counter (0x10) or of the accumulator (0x1E) latches its low byte. A following read of 0x11 or 0x1F returns the latched byte.
- R13: A write to a high-byte address (channel n at 2n, the counter at 0x10, the accumulator at 0x1E) changes nothing visible. The following low-byte write at the next address loads the full 16-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the read-side latching) |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| cap_in | input | 8 | Channel input pins, synchronous to clk |
| cmp_out | output | 8 | Channel output pins |
| pa_in | input | 1 | Accumulator input pin, synchronous to clk |
| irq_ch | output | 8 | Channel event flags |
| irq_ovf | output | 1 | Counter overflow flag |
| irq_pa | output | 1 | Accumulator overflow flag |

## Verification
The bench builds the block with GATE_LOG2 = 3. This brings a gated-time accumulator tick within eight cycles, so level-gated counting and the divider restart can be checked over windows a few tens of cycles long. The prescaler keeps its default 7-bit width, and the bench runs the divide-by-1 and divide-by-4 taps with exact tick counts. Loading the counter and accumulator near 0xFFFF brings both rollovers within a handful of cycles. Setting the channel 7 value to 9 gives a ten-tick modulo period, which is short enough to measure the pulse-width duty over ten full periods.

// File: rtl/tmr_pkg.sv
// Package: shared sizes, register addresses and field codes of the timer.
// Assumes a byte-wide bus with a 5-bit address.
package tmr_pkg;
    localparam int NCH  = 8;
    localparam int CW   = 16;
    localparam int AW   = 5;
    localparam int DW   = 8;

    localparam logic [AW-1:0] A_CNT_HI = 5'h10;
    localparam logic [AW-1:0] A_CNT_LO = 5'h11;
    localparam logic [AW-1:0] A_CTRL   = 5'h12;
    localparam logic [AW-1:0] A_MODE   = 5'h13;
    localparam logic [AW-1:0] A_EDGEL  = 5'h14;
    localparam logic [AW-1:0] A_EDGEH  = 5'h15;
    localparam logic [AW-1:0] A_ACTL   = 5'h16;
    localparam logic [AW-1:0] A_ACTH   = 5'h17;
    localparam logic [AW-1:0] A_FLAGC  = 5'h18;
    localparam logic [AW-1:0] A_FLAGM  = 5'h19;
    localparam logic [AW-1:0] A_PWMEN  = 5'h1A;
    localparam logic [AW-1:0] A_PACTL  = 5'h1C;
    localparam logic [AW-1:0] A_PA_HI  = 5'h1E;
    localparam logic [AW-1:0] A_PA_LO  = 5'h1F;

    typedef enum logic [1:0] {
        OC_NONE   = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_CLEAR  = 2'b10,
        OC_SET    = 2'b11
    } oc_act_e;
endpackage

// File: rtl/tmr_count.sv
// Module: prescaler and 16-bit main counter.
// Produces a tick once every 2^sel cycles while enabled. On each tick the counter
// advances, rolls over, or clears after the modulo top value.
// Assumes sel never exceeds PRE_W. A load has priority over a tick.
module tmr_count #(
    parameter int PRE_W = 7,
    parameter int CW    = 16,
    localparam int SEL_W = $clog2(PRE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             modulo,
    input  logic [CW-1:0]    top,
    input  logic             load,
    input  logic [CW-1:0]    load_val,
    output logic [CW-1:0]    cnt,
    output logic             tick,
    output logic             wrap,
    output logic             ovf_evt
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;
    logic             at_top;
    logic             at_max;

    // Build the tap mask: the low sel bits set.
    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    assign tick    = en && ((pre & mask) == mask);
    assign at_top  = modulo && (cnt == top);
    assign at_max  = (cnt == {CW{1'b1}});
    assign wrap    = tick && !load && (at_top || at_max);
    assign ovf_evt = tick && !load && at_max && !at_top;

    // Free-running prescaler, restarted whenever the counter is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) pre <= '0;
        else               pre <= pre + PRE_W'(1);
    end

    // Main counter: load, modulo clear, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (tick)   cnt <= at_top ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/tmr_chan.sv
// Module: one capture/compare channel.
// In capture mode, latches the counter on the selected pin edges. In compare mode,
// acts on its pin when the counter advances from the channel value.
// Assumes pin_in is already synchronous to clk.
module tmr_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wrap,
    input  logic [CW-1:0] cnt,
    input  logic          is_cmp,
    input  logic [1:0]    edge_sel,
    input  logic [1:0]    act,
    input  logic          pwm,
    input  logic          pin_in,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] val,
    output logic          evt,
    output logic          pin_out
);
    import tmr_pkg::*;

    logic prev;
    logic cap_hit;
    logic match;

    assign cap_hit = !is_cmp && ((edge_sel[0] && pin_in && !prev) ||
                                 (edge_sel[1] && !pin_in && prev));
    assign match   = is_cmp && tick && (cnt == val);
    assign evt     = cap_hit || match;

    // Remember the previous pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= pin_in;
    end

    // Channel value: bus load or captured counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       val <= '0;
        else if (load)    val <= load_val;
        else if (cap_hit) val <= cnt;
    end

    // Output pin: compare action first, then the pulse-width period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
        end else if (match && oc_act_e'(act) != OC_NONE) begin
            case (oc_act_e'(act))
                OC_TOGGLE: pin_out <= !pin_out;
                OC_CLEAR:  pin_out <= 1'b0;
                default:   pin_out <= 1'b1;
            endcase
        end else if (is_cmp && pwm && wrap) begin
            pin_out <= 1'b1;
        end
    end
endmodule

// File: rtl/tmr_accum.sv
// Module: 16-bit pulse accumulator.
// Counts active pin edges, or counts a 2^GATE_LOG2 divided clock while the pin is
// at its active level. The divider restarts when the block is disabled.
// Assumes pin is synchronous to clk. A load has priority over counting.
module tmr_accum #(
    parameter int CW        = 16,
    parameter int GATE_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          gated,
    input  logic          pol,
    input  logic          pin,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] acc,
    output logic          ovf_evt
);
    logic                 prev;
    logic [GATE_LOG2-1:0] gpre;
    logic                 gtick;
    logic                 edge_hit;
    logic                 inc;

    assign gtick    = en && (&gpre);
    assign edge_hit = pol ? (!pin && prev) : (pin && !prev);
    assign inc      = en && (gated ? (gtick && (pin ^ pol)) : edge_hit);
    assign ovf_evt  = inc && !load && (acc == {CW{1'b1}});

    // Previous pin level for the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= pin;
    end

    // Gate-time divider, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) gpre <= '0;
        else               gpre <= gpre + GATE_LOG2'(1);
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (load) acc <= load_val;
        else if (inc)  acc <= acc + CW'(1);
    end
endmodule

// File: rtl/tmr_pacc.sv
// Module: timer top. Holds the register file and flags on a byte bus, and ties
// together the counter, eight channels and the pulse accumulator.
// Assumes bus_wr and bus_rd are single-cycle strobes and that all pins are
// synchronous to clk. 16-bit values use a shared write stage and read hold byte.
module tmr_pacc #(
    parameter int PRE_W     = 7,
    parameter int GATE_LOG2 = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [4:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] cap_in,
    output logic [7:0] cmp_out,
    input  logic       pa_in,
    output logic [7:0] irq_ch,
    output logic       irq_ovf,
    output logic       irq_pa
);
    import tmr_pkg::*;

    localparam int SEL_W = $clog2(PRE_W + 1);

    logic               ctl_en, ctl_mod;
    logic [SEL_W-1:0]   ctl_sel;
    logic [NCH-1:0]     mode, pwm_en;
    logic [2*NCH-1:0]   edge_cfg, act_cfg;
    logic               pa_en, pa_gated, pa_pol;
    logic [DW-1:0]      stage, hold;
    logic [NCH-1:0]     ch_flag;
    logic               ovf_flag, pa_flag;

    logic [CW-1:0]          cnt, pa_acc, load_word;
    logic [NCH-1:0][CW-1:0] ch_val;
    logic [NCH-1:0]         ch_evt, ch_load;
    logic                   tick, wrap, cnt_ovf, pa_ovf;
    logic                   cnt_load, pa_load;
    logic [NCH-1:0]         clr_ch;
    logic [1:0]             clr_m;

    assign load_word = {stage, bus_wdata};
    assign cnt_load  = bus_wr && (bus_addr == A_CNT_LO);
    assign pa_load   = bus_wr && (bus_addr == A_PA_LO);
    assign clr_ch    = (bus_wr && bus_addr == A_FLAGC) ? bus_wdata : '0;
    assign clr_m     = (bus_wr && bus_addr == A_FLAGM) ? bus_wdata[1:0] : 2'b00;

    tmr_count #(.PRE_W(PRE_W), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .sel(ctl_sel), .modulo(ctl_mod),
        .top(ch_val[NCH-1]), .load(cnt_load), .load_val(load_word),
        .cnt(cnt), .tick(tick), .wrap(wrap), .ovf_evt(cnt_ovf)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_load[g] = bus_wr && !bus_addr[4] && bus_addr[0] &&
                            (bus_addr[3:1] == 3'(g));
        tmr_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .cnt(cnt),
            .is_cmp(mode[g]), .edge_sel(edge_cfg[2*g +: 2]), .act(act_cfg[2*g +: 2]),
            .pwm(pwm_en[g]), .pin_in(cap_in[g]), .load(ch_load[g]),
            .load_val(load_word), .val(ch_val[g]), .evt(ch_evt[g]),
            .pin_out(cmp_out[g])
        );
    end

    tmr_accum #(.CW(CW), .GATE_LOG2(GATE_LOG2)) u_pa (
        .clk(clk), .rst_n(rst_n), .en(pa_en), .gated(pa_gated), .pol(pa_pol),
        .pin(pa_in), .load(pa_load), .load_val(load_word),
        .acc(pa_acc), .ovf_evt(pa_ovf)
    );

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en <= 1'b0; ctl_mod <= 1'b0; ctl_sel <= '0;
            mode <= '0; pwm_en <= '0; edge_cfg <= '0; act_cfg <= '0;
            pa_en <= 1'b0; pa_gated <= 1'b0; pa_pol <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  begin
                    ctl_en  <= bus_wdata[7];
                    ctl_mod <= bus_wdata[6];
                    ctl_sel <= bus_wdata[SEL_W-1:0];
                end
                A_MODE:  mode <= bus_wdata;
                A_EDGEL: edge_cfg[7:0]  <= bus_wdata;
                A_EDGEH: edge_cfg[15:8] <= bus_wdata;
                A_ACTL:  act_cfg[7:0]   <= bus_wdata;
                A_ACTH:  act_cfg[15:8]  <= bus_wdata;
                A_PWMEN: pwm_en <= bus_wdata;
                A_PACTL: begin
                    pa_en    <= bus_wdata[0];
                    pa_gated <= bus_wdata[1];
                    pa_pol   <= bus_wdata[2];
                end
                default: ;
            endcase
        end
    end

    // High-byte write stage shared by all 16-bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else if (bus_wr && !bus_addr[0] &&
                 (!bus_addr[4] || bus_addr == A_CNT_HI || bus_addr == A_PA_HI))
            stage <= bus_wdata;
    end

    // Low-byte read hold, latched by a high-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)                             hold <= '0;
        else if (bus_rd && bus_addr == A_CNT_HI) hold <= cnt[7:0];
        else if (bus_rd && bus_addr == A_PA_HI)  hold <= pa_acc[7:0];
    end

    // Sticky flags: events set, write-one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_flag <= '0; ovf_flag <= 1'b0; pa_flag <= 1'b0;
        end else begin
            ch_flag  <= (ch_flag & ~clr_ch) | ch_evt;
            ovf_flag <= (ovf_flag && !clr_m[0]) || cnt_ovf;
            pa_flag  <= (pa_flag && !clr_m[1]) || pa_ovf;
        end
    end

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[4]) begin
            bus_rdata = bus_addr[0] ? ch_val[bus_addr[3:1]][7:0]
                                    : ch_val[bus_addr[3:1]][15:8];
        end else begin
            case (bus_addr)
                A_CNT_HI: bus_rdata = cnt[15:8];
                A_CNT_LO: bus_rdata = hold;
                A_CTRL:   bus_rdata = {ctl_en, ctl_mod, {(6-SEL_W){1'b0}}, ctl_sel};
                A_MODE:   bus_rdata = mode;
                A_EDGEL:  bus_rdata = edge_cfg[7:0];
                A_EDGEH:  bus_rdata = edge_cfg[15:8];
                A_ACTL:   bus_rdata = act_cfg[7:0];
                A_ACTH:   bus_rdata = act_cfg[15:8];
                A_FLAGC:  bus_rdata = ch_flag;
                A_FLAGM:  bus_rdata = {6'b0, pa_flag, ovf_flag};
                A_PWMEN:  bus_rdata = pwm_en;
                A_PACTL:  bus_rdata = {5'b0, pa_pol, pa_gated, pa_en};
                A_PA_HI:  bus_rdata = pa_acc[15:8];
                A_PA_LO:  bus_rdata = hold;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq_ch  = ch_flag;
    assign irq_ovf = ovf_flag;
    assign irq_pa  = pa_flag;
endmodule

// File: rtl/tmr_pacc_chk.sv
// Module: assertion checker for the timer top. It is attached by the bind below.
// Assumes it sees the counter tick, the counter value, the load strobe and the modulo top.
module tmr_pacc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        cnt_load,
    input logic        modulo,
    input logic [15:0] top,
    input logic [15:0] cnt,
    input logic        ovf_flag,
    input logic [7:0]  cmp_out
);
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_load) |=> $stable(cnt));                                   // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_load) |=> (cnt == $past(cnt) + 16'd1) || (cnt == 16'd0));   // R2
    AST_MOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_load && modulo && cnt == top) |=> (cnt == 16'd0));          // R4
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_load && cnt == 16'hFFFF && !(modulo && top == 16'hFFFF))
        |=> ovf_flag);                                                            // R3
    AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cmp_out));                                              // R6
endmodule

bind tmr_pacc tmr_pacc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_load(cnt_load), .modulo(ctl_mod),
    .top(ch_val[tmr_pkg::NCH-1]), .cnt(cnt), .ovf_flag(ovf_flag), .cmp_out(cmp_out)
);

// File: tb/sim_tmr_pacc.sv
// Directed bench for the timer. Inputs change on the falling edge, outputs are sampled there.
module sim_tmr_pacc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] cap_in = '0;
    logic [7:0] cmp_out;
    logic       pa_in = 1'b0;
    logic [7:0] irq_ch;
    logic       irq_ovf, irq_pa;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = !clk;

    tmr_pacc #(.PRE_W(7), .GATE_LOG2(3)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .cmp_out(cmp_out), .pa_in(pa_in),
        .irq_ch(irq_ch), .irq_ovf(irq_ovf), .irq_pa(irq_pa)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [4:0] a, input logic [15:0] v);
        wr(a, v[15:8]);
        wr(a + 5'd1, v[7:0]);
    endtask

    task automatic rd16(input logic [4:0] a, output logic [15:0] v);
        logic [7:0] h, l;
        rd(a, h);
        rd(a + 5'd1, l);
        v = {h, l};
    endtask

    task automatic pulse_pa(input int n);
        for (int i = 0; i < n; i++) begin
            pa_in = !pa_in; idle(2);
            pa_in = !pa_in; idle(2);
        end
    endtask

    task automatic t_reset;
        logic [7:0] b; logic [15:0] v;
        rd(5'h12, b);   chk("R1 ctrl", {8'h0, b}, 16'h0);
        rd16(5'h10, v); chk("R1 counter", v, 16'h0);
        rd16(5'h1E, v); chk("R1 accumulator", v, 16'h0);
        rd16(5'h0E, v); chk("R1 ch7 value", v, 16'h0);
        chk("R1 pins and flags", {cmp_out, irq_ch}, 16'h0);
        chk("R1 misc flags", {14'h0, irq_pa, irq_ovf}, 16'h0);
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        wr(5'h12, 8'h80); idle(24); wr(5'h12, 8'h00);
        rd16(5'h10, v); chk("R2 divide by 1", v, 16'd25);
        wr16(5'h10, 16'h0000);
        wr(5'h12, 8'h82); idle(41); wr(5'h12, 8'h02);
        rd16(5'h10, v); chk("R2 divide by 4", v, 16'd10);
        idle(20);
        rd16(5'h10, v); chk("R2 hold when disabled", v, 16'd10);
    endtask

    task automatic t_overflow;
        logic [15:0] v; logic [7:0] b;
        wr16(5'h10, 16'hFFFD);
        wr(5'h12, 8'h80); idle(4); wr(5'h12, 8'h00);
        rd16(5'h10, v); chk("R3 count past rollover", v, 16'h0002);
        rd(5'h19, b);   chk("R3 overflow flag", {8'h0, b}, 16'h0001);
        wr(5'h19, 8'h00); rd(5'h19, b); chk("R11 write zero keeps flag", {8'h0, b}, 16'h0001);
        wr(5'h19, 8'h01); rd(5'h19, b); chk("R11 write one clears flag", {8'h0, b}, 16'h0000);
    endtask

    task automatic t_modulo;
        logic [15:0] v; logic [7:0] b;
        wr16(5'h0E, 16'd9);
        wr16(5'h10, 16'd0);
        wr(5'h12, 8'hC0); idle(24); wr(5'h12, 8'h00);
        rd16(5'h10, v); chk("R4 modulo wrap", v, 16'd5);
        rd(5'h19, b);   chk("R4 no overflow flag", {8'h0, b}, 16'h0);
    endtask

    task automatic t_compare;
        logic [7:0] b;
        wr(5'h18, 8'hFF);
        wr(5'h13, 8'h0F);
        for (int c = 0; c < 4; c++) wr16(5'(2 * c), 16'd5);
        wr16(5'h08, 16'd5);
        wr(5'h16, 8'h3D);
        wr16(5'h10, 16'd0);
        wr(5'h12, 8'h80); idle(7); wr(5'h12, 8'h00);
        chk("R6 toggle/set/none pins", {8'h0, cmp_out}, 16'h0007);
        rd(5'h18, b); chk("R6 compare flags, capture ch4 quiet", {8'h0, b}, 16'h000F);
        wr(5'h16, 8'h39);
        wr16(5'h10, 16'd0);
        wr(5'h12, 8'h80); idle(7); wr(5'h12, 8'h00);
        chk("R6 toggle back and clear", {8'h0, cmp_out}, 16'h0004);
    endtask

    task automatic t_pwm;
        int highs = 0;
        wr(5'h13, 8'h1F);
        wr(5'h17, 8'h02);
        wr16(5'h08, 16'd3);
        wr(5'h1A, 8'h10);
        wr16(5'h10, 16'd0);
        wr(5'h12, 8'hC0);
        idle(10);
        for (int i = 0; i < 100; i++) begin
            if (cmp_out[4]) highs++;
            @(negedge clk);
        end
        wr(5'h12, 8'h00);
        chk("R7 pwm duty over ten periods", 16'(highs), 16'd40);
        wr(5'h1A, 8'h00);
    endtask

    task automatic t_capture;
        logic [15:0] v; logic [7:0] b;
        wr(5'h13, 8'h00);
        wr(5'h18, 8'hFF);
        wr(5'h14, 8'h10);
        wr(5'h15, 8'h38);
        wr16(5'h10, 16'h1234);
        cap_in[0] = 1'b1; cap_in[2] = 1'b1; idle(2);
        rd16(5'h04, v); chk("R5 rising capture ch2", v, 16'h1234);
        cap_in[5] = 1'b1; cap_in[6] = 1'b1; idle(2);
        rd16(5'h0A, v); chk("R5 falling-only ignores rise", v, 16'h0000);
        wr16(5'h10, 16'h5678);
        rd16(5'h0C, v); chk("R5 both edges, rise", v, 16'h1234);
        cap_in[5] = 1'b0; cap_in[6] = 1'b0; idle(2);
        rd16(5'h0A, v); chk("R5 falling capture ch5", v, 16'h5678);
        rd16(5'h0C, v); chk("R5 both edges, fall", v, 16'h5678);
        rd(5'h18, b); chk("R5 capture flags", {8'h0, b}, 16'h0064);
        wr(5'h18, 8'h04); rd(5'h18, b); chk("R11 clear one channel flag", {8'h0, b}, 16'h0060);
        cap_in = '0; idle(2);
    endtask

    task automatic t_accum;
        logic [15:0] v; logic [7:0] b;
        pulse_pa(2);
        rd16(5'h1E, v); chk("R8 disabled does not count", v, 16'd0);
        wr(5'h1C, 8'h01); pulse_pa(5);
        rd16(5'h1E, v); chk("R8 rising edges", v, 16'd5);
        wr16(5'h1E, 16'd0);
        wr(5'h1C, 8'h05); pa_in = 1'b1; idle(2); pa_in = 1'b0; idle(2);
        pulse_pa(0); pa_in = 1'b1; idle(2); pa_in = 1'b0; idle(2);
        rd16(5'h1E, v); chk("R8 falling edges", v, 16'd2);
        wr(5'h1C, 8'h00);
        wr16(5'h1E, 16'hFFFE);
        wr(5'h1C, 8'h01); pulse_pa(3); wr(5'h1C, 8'h00);
        rd16(5'h1E, v); chk("R10 accumulator wraps", v, 16'd1);
        rd(5'h19, b);   chk("R10 accumulator flag", {8'h0, b}, 16'h0002);
        wr(5'h19, 8'h02);
        wr16(5'h1E, 16'd0);
        pa_in = 1'b1; idle(1);
        wr(5'h1C, 8'h03); idle(39); wr(5'h1C, 8'h00);
        rd16(5'h1E, v); chk("R9 gated high", v, 16'd5);
        pa_in = 1'b0; idle(1);
        wr(5'h1C, 8'h03); idle(39); wr(5'h1C, 8'h00);
        rd16(5'h1E, v); chk("R9 gate closed", v, 16'd5);
        wr(5'h1C, 8'h07); idle(23); wr(5'h1C, 8'h00);
        rd16(5'h1E, v); chk("R9 active-low gate", v, 16'd8);
    endtask

    task automatic t_bytes;
        logic [15:0] v; logic [7:0] h, l;
        wr16(5'h06, 16'h0005);
        wr(5'h06, 8'hAB);
        rd16(5'h06, v); chk("R13 high byte alone staged", v, 16'h0005);
        wr(5'h07, 8'hCD);
        rd16(5'h06, v); chk("R13 low byte commits", v, 16'hABCD);
        wr16(5'h10, 16'h01FF);
        wr(5'h12, 8'h80);
        rd(5'h10, h); rd(5'h11, l);
        wr(5'h12, 8'h00);
        chk("R12 coherent counter read", {h, l}, 16'h01FF);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_prescale();
        t_overflow();
        t_modulo();
        t_compare();
        t_pwm();
        t_capture();
        t_accum();
        t_bytes();
        finish_run();
    end
endmodule